// File: doc/BRIEF.md
# Dual-Lane Seven-to-One Word Serializer

This block turns a 14-bit parallel word into two serial streams. The low seven bits go out on one lane and the high seven bits go out on the other. Both lanes shift together, one bit per cycle of a fast bit clock. A forwarded clock output runs at the word rate and marks where each word starts. The parallel word is presented with a slow word clock that runs at one seventh of the bit rate. A select input chooses whether its rising or its falling edge captures the word. The word clock is sampled in the bit-clock domain.

An active-high enable gates everything. While it is low, every output-enable is deasserted, which stands for high impedance. All serializer state is also cleared. After enable returns, the outputs stay idle until a capture edge arrives. Enable and the clocks can come in any order. A word clock that stops and later restarts needs no enable cycle: while it is stopped, the last captured word repeats.

Top module: `lane_serializer`

## Requirements
- R1: Bits 6..0 of `dataIn` leave on `serData[0]` and bits 13..7 leave on `serData[1]`, in the same bit-clock cycles.
- R2: Within a word, each lane sends bit 0 first, then one bit per bit-clock cycle up to bit 6, for seven cycles per word.
- R3: With `edgeSel` = 1 a word is captured when the sampled `wordClk` goes 0 to 1; with `edgeSel` = 0, when it goes 1 to 0. When the lanes are idle, bit 0 of the captured word appears on the cycle after the edge is sampled.
- R4: `fwdClk` is high for four bit cycles and low for three, repeating every seven cycles. It rises in the same cycle that bit 0 of a word is presented.
- R5: A newly captured word follows the previous one directly at the seven-cycle boundary, with no bit dropped or repeated. If no capture edge has come since the last boundary, the last captured word is sent again.
- R6: A cycle after `enable` or `rstN` is sampled low, `serOe`, `fwdClkOe`, `serData` and `fwdClk` are all 0, and nothing captured before is sent afterwards.
- R7: After enable rises, all outputs and output-enables stay 0 until the first capture edge. Every output-enable then goes to 1.
- R8: Holding `wordClk` still and then restarting it, with `enable` held high throughout, resumes normal serialization with no enable cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, seven times the word rate |
| rstN | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Active-high block enable; low clears the block and tri-states the outputs |
| wordClk | input | 1 | Word clock, sampled on `clk` |
| edgeSel | input | 1 | 1 selects the rising word-clock edge for capture, 0 selects the falling edge |
| dataIn | input | 14 | Parallel word; [6:0] go to lane 0, [13:7] go to lane 1 |
| serData | output | 2 | Serial bit of each lane |
| serOe | output | 2 | Output-enable of each lane |
| fwdClk | output | 1 | Forwarded word-rate clock |
| fwdClkOe | output | 1 | Output-enable of the forwarded clock |

## Verification
The bench builds the block with its default parameters: seven bits per lane, two lanes and a four-cycle high phase. These are the values a 14-bit word over two lanes needs. With them, the seven-cycle boundary, the 4/3 clock shape and the split between lane 0 and lane 1 all become observable in every word. A bench-side queue model follows both capture polarities, a disable in the middle of a word, and a word clock that stops and then restarts with a shifted phase. That last case moves capture edges away from the counter's boundary.

// File: rtl/lane_serializer_pkg.sv
package lane_serializer_pkg;
  // strobes from the control into the datapath
  typedef struct packed {
    logic clear;    // wipe all state
    logic capture;  // a selected word-clock edge was sampled
    logic load;     // move a word into the lane shifters
    logic direct;   // take the word straight from the input
  } serCtl_t;
endpackage

// File: rtl/lane_serializer_ctrl.sv
module lane_serializer_ctrl
  import lane_serializer_pkg::*;
#(
  parameter int BITS_PER_LANE = 7,
  parameter int HIGH_BITS     = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  logic    wordClk,
  input  logic    edgeSel,
  output serCtl_t ctl,
  output logic    fwdClk,
  output logic    running
);
  localparam int CW = $clog2(BITS_PER_LANE);
  localparam logic [CW-1:0] LAST = CW'(BITS_PER_LANE - 1);
  localparam logic [CW-1:0] HIGHC = CW'(HIGH_BITS);

  logic          wcPrev;
  logic          selEdge;
  logic          wrap;
  logic [CW-1:0] bitCnt;

  // plain sampler of the word clock; runs even when disabled
  always_ff @(posedge clk) wcPrev <= wordClk;

  assign selEdge = edgeSel ? (wordClk & ~wcPrev) : (~wordClk & wcPrev);
  assign wrap    = running && (bitCnt == LAST);

  always_comb begin
    ctl.clear   = !rstN || !enable;
    ctl.capture = selEdge;
    ctl.load    = (!running && selEdge) || wrap;
    ctl.direct  = selEdge;
  end

  always_ff @(posedge clk) begin
    if (ctl.clear) begin
      running <= 1'b0;
      bitCnt  <= '0;
    end else begin
      if (selEdge) running <= 1'b1;
      if (ctl.load)     bitCnt <= '0;
      else if (running) bitCnt <= bitCnt + 1'b1;
    end
  end

  assign fwdClk = running && (bitCnt < HIGHC);
endmodule

// File: rtl/lane_serializer_dp.sv
module lane_serializer_dp
  import lane_serializer_pkg::*;
#(
  parameter int BITS_PER_LANE = 7,
  parameter int LANES         = 2
) (
  input  logic                           clk,
  input  serCtl_t                        ctl,
  input  logic [LANES*BITS_PER_LANE-1:0] dataIn,
  output logic [LANES-1:0]               laneBit
);
  localparam int WW = LANES * BITS_PER_LANE;

  logic [WW-1:0] holdWord;
  logic [WW-1:0] nextWord;

  always_ff @(posedge clk) begin
    if (ctl.clear)        holdWord <= '0;
    else if (ctl.capture) holdWord <= dataIn;
  end

  assign nextWord = ctl.direct ? dataIn : holdWord;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [BITS_PER_LANE-1:0] shreg;
    always_ff @(posedge clk) begin
      if (ctl.clear)     shreg <= '0;
      else if (ctl.load) shreg <= nextWord[l*BITS_PER_LANE +: BITS_PER_LANE];
      else               shreg <= {1'b0, shreg[BITS_PER_LANE-1:1]};
    end
    assign laneBit[l] = shreg[0];
  end
endmodule

// File: rtl/lane_serializer.sv
module lane_serializer
  import lane_serializer_pkg::*;
#(
  parameter int BITS_PER_LANE = 7,
  parameter int LANES         = 2,
  parameter int HIGH_BITS     = 4,
  localparam int WW = LANES * BITS_PER_LANE
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             wordClk,
  input  logic             edgeSel,
  input  logic [WW-1:0]    dataIn,
  output logic [LANES-1:0] serData,
  output logic [LANES-1:0] serOe,
  output logic             fwdClk,
  output logic             fwdClkOe
);
  serCtl_t ctl;
  logic    running;
  logic    clkRaw;

  lane_serializer_ctrl #(.BITS_PER_LANE(BITS_PER_LANE), .HIGH_BITS(HIGH_BITS)) i_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .wordClk(wordClk), .edgeSel(edgeSel),
    .ctl(ctl), .fwdClk(clkRaw), .running(running)
  );

  lane_serializer_dp #(.BITS_PER_LANE(BITS_PER_LANE), .LANES(LANES)) i_dp (
    .clk(clk), .ctl(ctl), .dataIn(dataIn), .laneBit(serData)
  );

  assign fwdClk   = clkRaw;
  assign fwdClkOe = running;
  assign serOe    = {LANES{running}};
endmodule

// File: rtl/lane_serializer_chk.sv
module lane_serializer_chk #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             wordClk,
  input logic [LANES-1:0] serData,
  input logic [LANES-1:0] serOe,
  input logic             fwdClk,
  input logic             fwdClkOe
);
  a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (serOe == '0 && !fwdClkOe && serData == '0 && !fwdClk));

  a_r7_oe_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fwdClkOe) |-> $past(enable));

  a_r3_start_after_edge: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fwdClkOe) |-> ($past(wordClk) != $past(wordClk, 2)));

  a_r4_first_bit_with_clock: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fwdClkOe) |-> fwdClk);

  a_r4_high_four: assert property (@(posedge clk) disable iff (!rstN || !enable)
    $rose(fwdClk) |=> fwdClk ##1 fwdClk ##1 fwdClk);

  a_r7_idle_outputs_low: assert property (@(posedge clk) disable iff (!rstN)
    !fwdClkOe |-> (serData == '0 && !fwdClk));
endmodule

bind lane_serializer lane_serializer_chk #(.LANES(LANES)) i_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .wordClk(wordClk),
  .serData(serData), .serOe(serOe), .fwdClk(fwdClk), .fwdClkOe(fwdClkOe)
);

// File: tb/test_lane_serializer.sv
module test_lane_serializer;
  logic clk = 1'b0;
  logic rstN = 1'b0, enable = 1'b0, wordClk = 1'b0, edgeSel = 1'b1;
  logic [13:0] dataIn = '0;
  logic [1:0] serData, serOe;
  logic fwdClk, fwdClkOe;

  int total = 0, bad = 0;
  int cyc = 0;
  bit wcRun = 0;
  int wph = 0;

  always #4 clk = ~clk;

  lane_serializer i_lane_serializer (
    .clk(clk), .rstN(rstN), .enable(enable), .wordClk(wordClk), .edgeSel(edgeSel),
    .dataIn(dataIn), .serData(serData), .serOe(serOe), .fwdClk(fwdClk), .fwdClkOe(fwdClkOe)
  );

  // behavioural reference: queues of bits still to send
  bit qA[$], qB[$];
  bit run = 0, prevWc = 0;
  logic [13:0] lastWord = '0;
  bit eA = 0, eB = 0, eC = 0, eOe = 0;
  always @(posedge clk) begin
    bit ed;
    int idx;
    ed = edgeSel ? (wordClk && !prevWc) : (!wordClk && prevWc);
    if (!rstN || !enable) begin
      run = 0; qA.delete(); qB.delete();
      eA = 0; eB = 0; eC = 0; eOe = 0;
    end else begin
      if (ed) lastWord = dataIn;
      if (run || ed) begin
        run = 1;
        if (qA.size() == 0)
          for (int i = 0; i < 7; i++) begin
            qA.push_back(lastWord[i]);
            qB.push_back(lastWord[7+i]);
          end
        idx = 7 - qA.size();
        eA = qA.pop_front();
        eB = qB.pop_front();
        eC = (idx < 4);
        eOe = 1;
      end
    end
    prevWc = wordClk;
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  // one bench cycle: compare at the falling edge, then drive new inputs
  task automatic tick();
    @(negedge clk);
    cyc++;
    chk(serData[0] == eA, "R1/R2/R5 lane0", serData[0], eA);
    chk(serData[1] == eB, "R1/R2/R5 lane1", serData[1], eB);
    chk(fwdClk == eC, "R4 fwdClk", fwdClk, eC);
    chk(fwdClkOe == eOe && serOe == {2{eOe}}, "R6/R7 oe", {serOe, fwdClkOe}, {2'(eOe * 3), eOe});
    if (wcRun) begin
      wph = (wph + 1) % 7;
      wordClk = (wph < 4);
      // change data on the edge that is not used for capture
      if ((edgeSel && wph == 4) || (!edgeSel && wph == 0)) dataIn = 14'($urandom);
    end
  endtask

  task automatic run_n(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #1500000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    run_n(3);
    // R6 reset state
    chk(serOe == 0 && fwdClkOe == 0 && serData == 0, "R6 reset", {serOe, serData}, 0);
    rstN = 1; enable = 1;
    run_n(5);
    // R7: idle while no word clock is running
    chk(fwdClkOe == 0 && fwdClk == 0, "R7 idle before capture", fwdClkOe, 0);
    dataIn = 14'h2A5B;
    wcRun = 1;
    run_n(120);                       // R3 rising-edge capture
    edgeSel = 0;
    run_n(100);                       // R3 falling-edge capture
    enable = 0;                       // R6 disable mid-stream
    run_n(2);
    chk(fwdClkOe == 0 && serData == 0, "R6 disabled", {fwdClkOe, serData}, 0);
    run_n(10);
    enable = 1; edgeSel = 1;
    run_n(60);
    wcRun = 0;                        // R8 stop word clock, last word repeats (R5)
    run_n(30);
    wph = 2;                          // R8 restart with shifted phase
    wcRun = 1;
    run_n(100);
    chk(fwdClkOe == 1, "R8 running after restart", fwdClkOe, 1);
    rstN = 0;
    run_n(2);
    chk(fwdClkOe == 0 && fwdClk == 0, "R6 reset again", fwdClkOe, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule